// File: doc/BRIEF.md
# Programmable YUV to RGB Colour Matrix

This block converts a stream of limited-range 8-bit luma and chroma samples into full-range 8-bit red, green and blue. Each output channel is one row of a 3×4 matrix: a luma weight, a blue-difference weight, a red-difference weight and an additive offset. The weights are signed fixed-point numbers scaled by 1024 and the offsets are signed numbers scaled by 16. The twelve entries sit in a register bank. After reset the bank holds the standard-definition broadcast conversion, and a simple indexed write port can reload any entry at any time.

Pixels enter on a valid/ready handshake and leave on another valid/ready handshake three pipeline stages later. The three stages are: multiply, sum with a rounding offset, and shift with a clamp to 0–255. The whole pipe stalls together when the output is held, so no pixel is dropped or reordered. A write to the bank takes effect for every pixel accepted after the write's clock edge. A pixel accepted at the same edge still uses the old value.

Top module: `yuvmat_top`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and the bank holds the default matrix. With that matrix, (Y,U,V)=(16,128,128) gives RGB (0,0,0), (235,128,128) gives (255,255,255) and (0,0,0) gives R=0, G=135, B=0.
- R2: Each channel equals floor((Y·cy + U·cu + V·cv + k·64 + 512) / 1024), computed with Y, U and V as unsigned numbers. This rounds half up.
- R3: A channel result below 0 leaves as 0, and a result above 255 leaves as 255.
- R4: In `cfg_data`, bits 12:0 carry a weight as 13-bit two's complement and bits 13:0 carry an offset as 14-bit two's complement. For example, 0x1C00 means −1024 and 0x39C0 means −1600.
- R5: Bank index = 4·row + column. Rows are 0 = G, 1 = R, 2 = B. Columns are 0 = luma weight, 1 = U weight, 2 = V weight, 3 = offset.
- R6: A write with `cfg_idx` in 12–15 changes no entry.
- R7: A pixel uses the bank contents from before its accept edge. A write at the same edge applies only to later pixels.
- R8: With `out_ready` held high, a pixel accepted at edge k is presented with `out_valid` high after edge k+2. At most three pixels are in flight.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` and the output channels hold steady. Every accepted pixel leaves exactly once, in order.
- R10: `in_ready` is high exactly when the output stage is empty or is being read in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Bank write strobe |
| cfg_idx | input | 4 | Bank entry index |
| cfg_data | input | 14 | Entry value (weights use bits 12:0) |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Input pixel taken this cycle |
| in_y | input | 8 | Luma sample |
| in_u | input | 8 | Blue-difference sample |
| in_v | input | 8 | Red-difference sample |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Consumer takes output pixel |
| out_r | output | 8 | Red |
| out_g | output | 8 | Green |
| out_b | output | 8 | Blue |

## Verification
A wrong bank entry or a mis-mapped index shows up in the very next converted pixel, three cycles after it is accepted, as a channel that differs from the arithmetic expectation. A fault in the stall logic shows within one cycle of a held output, as a changed value or a dropped `out_valid`. It also shows as a pixel missing from the ordered scoreboard by the time the stream drains. Sweeps over the sample grid with two different matrices and random backpressure expose sign-extension, rounding and clamp faults at the channel boundaries.

// File: rtl/yuvmat_pkg.sv
package yuvmat_pkg;

    localparam int NUM_ROWS = 3;
    localparam int NUM_COLS = 4;
    localparam int NUM_ENT  = NUM_ROWS * NUM_COLS;

    typedef enum logic [1:0] {
        ROW_G = 2'd0,
        ROW_R = 2'd1,
        ROW_B = 2'd2
    } row_e;

    typedef enum logic [1:0] {
        COL_Y = 2'd0,
        COL_U = 2'd1,
        COL_V = 2'd2,
        COL_K = 2'd3
    } col_e;

    // Standard-definition conversion, weights x1024, offsets x16
    function automatic logic [15:0] default_entry(input int idx);
        logic [15:0] val;
        unique case (idx)
            0:       val = 16'h04A7;
            1:       val = 16'h1E6F;
            2:       val = 16'h1CBF;
            3:       val = 16'h0877;
            4:       val = 16'h04A7;
            5:       val = 16'h0000;
            6:       val = 16'h0662;
            7:       val = 16'h3211;
            8:       val = 16'h04A7;
            9:       val = 16'h0812;
            10:      val = 16'h0000;
            11:      val = 16'h2EB1;
            default: val = 16'h0000;
        endcase
        return val;
    endfunction

endpackage

// File: rtl/yuvmat_coef_bank.sv
module yuvmat_coef_bank
    import yuvmat_pkg::*;
#(
    parameter int CW   = 13,
    parameter int KW   = 14,
    parameter int IDXW = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [IDXW-1:0]                    wr_idx,
    input  logic [KW-1:0]                      wr_data,
    output logic [NUM_ROWS-1:0][2:0][CW-1:0]   weight_o,
    output logic [NUM_ROWS-1:0][KW-1:0]        offset_o
);

    logic [KW-1:0] entry_q [NUM_ENT];

    for (genvar e = 0; e < NUM_ENT; e++) begin : g_entry
        localparam logic [15:0] DFLT = default_entry(e);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entry_q[e] <= DFLT[KW-1:0];
            end else if (wr_en && (wr_idx == IDXW'(e))) begin
                entry_q[e] <= wr_data;
            end
        end
    end

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        for (genvar c = 0; c < 3; c++) begin : g_col
            assign weight_o[r][c] = entry_q[r*NUM_COLS + c][CW-1:0];
        end
        assign offset_o[r] = entry_q[r*NUM_COLS + int'(COL_K)];
    end

endmodule

// File: rtl/yuvmat_row.sv
module yuvmat_row #(
    parameter int DW = 8,
    parameter int CW = 13,
    parameter int CF = 10,
    parameter int KW = 14,
    parameter int KF = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  logic [DW-1:0]       smp_y,
    input  logic [DW-1:0]       smp_u,
    input  logic [DW-1:0]       smp_v,
    input  logic [2:0][CW-1:0]  weight,
    input  logic [KW-1:0]       offset,
    output logic [DW-1:0]       chan
);

    localparam int PW  = DW + 1 + CW;
    localparam int SW  = PW + 4;
    localparam int SH  = CF - KF;
    localparam logic signed [SW-1:0] RND  = SW'(1) <<< (CF - 1);
    localparam logic signed [SW-1:0] MAXV = SW'((1 << DW) - 1);

    // stage 1: products
    logic signed [PW-1:0] prod_q [3];
    logic signed [SW-1:0] koff_q;
    // stage 2: rounded sum
    logic signed [SW-1:0] sum_q;

    logic signed [DW:0]   smp_s [3];
    logic signed [SW-1:0] shifted;

    assign smp_s[0] = signed'({1'b0, smp_y});
    assign smp_s[1] = signed'({1'b0, smp_u});
    assign smp_s[2] = signed'({1'b0, smp_v});

    for (genvar c = 0; c < 3; c++) begin : g_mul
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prod_q[c] <= '0;
            end else if (adv) begin
                prod_q[c] <= PW'(smp_s[c]) * PW'(signed'(weight[c]));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            koff_q <= '0;
        end else if (adv) begin
            koff_q <= SW'(signed'(offset)) <<< SH;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (adv) begin
            sum_q <= SW'(prod_q[0]) + SW'(prod_q[1]) + SW'(prod_q[2]) + koff_q + RND;
        end
    end

    assign shifted = sum_q >>> CF;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan <= '0;
        end else if (adv) begin
            if (shifted < 0) begin
                chan <= '0;
            end else if (shifted > MAXV) begin
                chan <= MAXV[DW-1:0];
            end else begin
                chan <= shifted[DW-1:0];
            end
        end
    end

endmodule

// File: rtl/yuvmat_flow.sv
module yuvmat_flow #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic adv,
    output logic in_ready,
    output logic out_valid
);

    logic [STAGES-1:0] occ_q;

    assign out_valid = occ_q[STAGES-1];
    assign adv       = !occ_q[STAGES-1] || out_ready;
    assign in_ready  = adv;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else if (adv) begin
            occ_q <= {occ_q[STAGES-2:0], in_valid};
        end
    end

endmodule

// File: rtl/yuvmat_top.sv
module yuvmat_top
    import yuvmat_pkg::*;
#(
    parameter int DW   = 8,
    parameter int CW   = 13,
    parameter int CF   = 10,
    parameter int KW   = 14,
    parameter int KF   = 4,
    parameter int IDXW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDXW-1:0]  cfg_idx,
    input  logic [KW-1:0]    cfg_data,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [DW-1:0]    in_y,
    input  logic [DW-1:0]    in_u,
    input  logic [DW-1:0]    in_v,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [DW-1:0]    out_r,
    output logic [DW-1:0]    out_g,
    output logic [DW-1:0]    out_b
);

    localparam int STAGES = 3;

    logic                             adv;
    logic [NUM_ROWS-1:0][2:0][CW-1:0] weight;
    logic [NUM_ROWS-1:0][KW-1:0]      offset;
    logic [NUM_ROWS-1:0][DW-1:0]      chan;

    yuvmat_coef_bank #(.CW(CW), .KW(KW), .IDXW(IDXW)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_data  (cfg_data),
        .weight_o (weight),
        .offset_o (offset)
    );

    yuvmat_flow #(.STAGES(STAGES)) u_flow (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .adv       (adv),
        .in_ready  (in_ready),
        .out_valid (out_valid)
    );

    for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
        yuvmat_row #(.DW(DW), .CW(CW), .CF(CF), .KW(KW), .KF(KF)) u_row (
            .clk    (clk),
            .rst_n  (rst_n),
            .adv    (adv),
            .smp_y  (in_y),
            .smp_u  (in_u),
            .smp_v  (in_v),
            .weight (weight[r]),
            .offset (offset[r]),
            .chan   (chan[r])
        );
    end

    assign out_g = chan[int'(ROW_G)];
    assign out_r = chan[int'(ROW_R)];
    assign out_b = chan[int'(ROW_B)];

endmodule

// File: rtl/yuvmat_checker.sv
module yuvmat_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic          out_ready,
    input logic [DW-1:0] out_r,
    input logic [DW-1:0] out_g,
    input logic [DW-1:0] out_b
);

    logic [2:0] inflight_q;
    logic       take_in;
    logic       take_out;

    assign take_in  = in_valid && in_ready;
    assign take_out = out_valid && out_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight_q <= '0;
        end else begin
            inflight_q <= inflight_q + 3'(take_in) - 3'(take_out);
        end
    end

    p_hold_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> out_valid);

    p_hold_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable({out_r, out_g, out_b}));

    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_in ##1 out_ready ##1 out_ready |=> out_valid);

    p_occupancy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q <= 3'd3);

    p_no_phantom_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (inflight_q != 3'd0));

endmodule

bind yuvmat_top yuvmat_checker #(.DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_r     (out_r),
    .out_g     (out_g),
    .out_b     (out_b)
);

// File: tb/yuvmat_top_test.sv
`timescale 1ns/1ps
module yuvmat_top_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [3:0]  cfg_idx;
    logic [13:0] cfg_data;
    logic        in_valid;
    logic        in_ready;
    logic [7:0]  in_y, in_u, in_v;
    logic        out_valid;
    logic        out_ready;
    logic [7:0]  out_r, out_g, out_b;

    int checks = 0;
    int errors = 0;

    int model [12];
    int exp_q [$];
    logic last_fire;
    logic prev_stall;
    logic [23:0] prev_rgb;

    always #2 clk = ~clk;

    yuvmat_top uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_y(in_y), .in_u(in_u), .in_v(in_v),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    function automatic int sext(input int val, input int w);
        int m = val & ((1 << w) - 1);
        if (m >= (1 << (w - 1))) m = m - (1 << w);
        return m;
    endfunction

    function automatic int chan_of(input int row, input int y, input int u, input int v);
        int acc;
        acc = y * sext(model[row*4], 13) + u * sext(model[row*4+1], 13)
            + v * sext(model[row*4+2], 13) + sext(model[row*4+3], 14) * 64 + 512;
        acc = acc >>> 10;
        if (acc < 0) acc = 0;
        if (acc > 255) acc = 255;
        return acc;
    endfunction

    function automatic int pack_exp(input int y, input int u, input int v);
        return (chan_of(1, y, u, v) << 16) | (chan_of(0, y, u, v) << 8) | chan_of(2, y, u, v);
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    task automatic load_defaults();
        model[0] = 'h4A7; model[1] = 'h1E6F; model[2]  = 'h1CBF; model[3]  = 'h877;
        model[4] = 'h4A7; model[5] = 0;      model[6]  = 'h662;  model[7]  = 'h3211;
        model[8] = 'h4A7; model[9] = 'h812;  model[10] = 0;      model[11] = 'h2EB1;
    endtask

    task automatic cfg_write(input int idx, input int data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_data = 14'(data);
        @(posedge clk);
        if (idx < 12) model[idx] = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // one pixel through an idle pipe with out_ready held high
    task automatic one_pixel(input int y, input int u, input int v,
                             input int er, input int eg, input int eb, input string req);
        @(negedge clk);
        out_ready = 1'b1; in_valid = 1'b1;
        in_y = 8'(y); in_u = 8'(u); in_v = 8'(v);
        #1 check(in_ready, "R10 idle in_ready", int'(in_ready), 1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        #1 check(!out_valid, "R8 not valid after k", int'(out_valid), 0);
        @(posedge clk);
        @(negedge clk);
        #1 check(!out_valid, "R8 not valid after k+1", int'(out_valid), 0);
        @(posedge clk);
        @(negedge clk);
        #1 check(out_valid, "R8 valid after k+2", int'(out_valid), 1);
        check({out_r, out_g, out_b} == 24'((er << 16) | (eg << 8) | eb), req,
              int'({out_r, out_g, out_b}), (er << 16) | (eg << 8) | eb);
        @(posedge clk);
    endtask

    // one streaming cycle with scoreboard
    task automatic step(input logic iv, input int y, input int u, input int v,
                        input logic ordy, input logic we, input int widx, input int wdata);
        logic fire_out;
        int   expv;
        @(negedge clk);
        in_valid = iv; in_y = 8'(y); in_u = 8'(u); in_v = 8'(v);
        out_ready = ordy;
        cfg_we = we; cfg_idx = 4'(widx); cfg_data = 14'(wdata);
        #1;
        if (prev_stall) begin
            check(out_valid && ({out_r, out_g, out_b} == prev_rgb), "R9 hold under stall",
                  int'({out_r, out_g, out_b}), int'(prev_rgb));
        end
        check(in_ready == (!out_valid || out_ready), "R10 in_ready rule",
              int'(in_ready), int'(!out_valid || out_ready));
        last_fire = iv && in_ready;
        fire_out  = out_valid && out_ready;
        if (fire_out) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected output", int'({out_r, out_g, out_b}), 0);
            end else begin
                expv = exp_q.pop_front();
                check({out_r, out_g, out_b} == 24'(expv), "R2/R3 channel value",
                      int'({out_r, out_g, out_b}), expv);
            end
        end
        if (last_fire) exp_q.push_back(pack_exp(y, u, v));
        if (we && widx < 12) model[widx] = wdata;
        prev_stall = out_valid && !out_ready;
        prev_rgb   = {out_r, out_g, out_b};
        @(posedge clk);
    endtask

    task automatic sweep(input int mid_idx, input int mid_data);
        int n = 0;
        for (int y = 0; y < 256; y += 5) begin
            for (int u = 0; u < 256; u += 17) begin
                for (int v = 0; v < 256; v += 17) begin
                    logic wr = (n == 500) && (mid_idx >= 0);
                    do begin
                        step(1'b1, y, u, v, ($urandom_range(0, 3) != 0), wr, mid_idx, mid_data);
                        wr = 1'b0;
                    end while (!last_fire);
                    n++;
                end
            end
        end
        for (int i = 0; i < 12; i++) step(1'b0, 0, 0, 0, 1'b1, 1'b0, 0, 0);
        @(negedge clk);
        check(exp_q.size() == 0, "R9 all pixels drained", exp_q.size(), 0);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_data = '0;
        in_valid = 1'b0; in_y = '0; in_u = '0; in_v = '0; out_ready = 1'b0;
        prev_stall = 1'b0; prev_rgb = '0; last_fire = 1'b0;
        load_defaults();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!out_valid, "R1 reset out_valid", int'(out_valid), 0);
        check(in_ready, "R1 reset in_ready", int'(in_ready), 1);

        // R1 defaults at known points
        one_pixel(16, 128, 128, 0, 0, 0, "R1 black");
        one_pixel(235, 128, 128, 255, 255, 255, "R1 white");
        one_pixel(0, 0, 0, 0, 135, 0, "R1 R3 zero input");

        // R2 R3 R9 default sweep under backpressure
        sweep(-1, 0);

        // R4 R5 custom matrix: G = Y/2, R = 255-U, B = Y+V-100
        cfg_write(0, 512);     cfg_write(1, 0);      cfg_write(2, 0);      cfg_write(3, 0);
        cfg_write(4, 0);       cfg_write(5, 'h1C00); cfg_write(6, 0);      cfg_write(7, 4080);
        cfg_write(8, 1024);    cfg_write(9, 0);      cfg_write(10, 1024);  cfg_write(11, 'h39C0);
        one_pixel(10, 20, 30, 235, 5, 0, "R5 R4 custom mapping");
        one_pixel(1, 0, 0, 255, 1, 0, "R2 round half up");
        one_pixel(3, 255, 0, 0, 2, 0, "R2 R3 rounding and low clamp");
        one_pixel(200, 0, 200, 255, 100, 255, "R3 high clamp");

        // R6 out-of-range writes ignored
        for (int i = 12; i < 16; i++) cfg_write(i, 0);
        one_pixel(10, 20, 30, 235, 5, 0, "R6 index 12-15 ignored");

        // R7 mid-stream write of G luma weight, plus R2 R9 sweep
        sweep(0, 1024);
        one_pixel(40, 0, 0, 255, 40, 0, "R7 write took effect");

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule